// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Control

This block resolves read-after-write hazards in a five-stage in-order integer pipeline. Each cycle it compares the source register numbers of the instruction in the execute stage with the destination register numbers of the two older instructions still in flight. It then picks, for each of the two ALU operands, where the operand value comes from: the register file read, the result held after execute, or the result held after memory access. When a newer and an older instruction both target the same source register, the newer result wins.

A loaded value is not ready early enough to forward to the very next instruction. For that case the block compares the load's target with both source fields of the instruction being decoded. On a match it freezes the program counter and the decode register for one cycle, and it tells the pipeline to clear the control bits entering execute. The register numbers and data in that slot are left as they are. In the following cycle the cleared slot no longer reads memory, so the stall drops. The dependent instruction then picks up the loaded value from the post-memory forwarding path.

All outputs are combinational functions of the current inputs. There is no internal state and no data stream, so every pin is a plain control or status signal.

Top module: `hz_unit`

## Requirements
- R1: `fwd_a` is 2'b10 (use the post-execute result) when `exmem_wr` is 1, `exmem_rd` is not 0 and `exmem_rd` equals `idex_rs`.
- R2: `fwd_a` is 2'b01 (use the post-memory result) when `memwb_wr` is 1, `memwb_rd` is not 0, `memwb_rd` equals `idex_rs`, and the R1 condition is false.
- R3: When both the R1 and R2 conditions hold for an operand, the select is 2'b10; the newer result takes priority.
- R4: A source register number of 0 is never forwarded; its select is 2'b00.
- R5: A stage whose write enable is 0 is never forwarded from, even when its destination matches.
- R6: `fwd_b` follows the same rules as `fwd_a` but compares against `idex_rt`, independently of `fwd_a`.
- R7: Select 2'b00 means the register file value. Code 2'b11 never appears on either select.
- R8: `pc_hold`, `ifid_hold` and `idex_bubble` are all 1 when `idex_mem_rd` is 1 and `idex_rt` equals `ifid_rs` or `ifid_rt`; otherwise all three are 0.
- R9: With `idex_mem_rd` at 0, no stall or bubble is raised, whatever the register numbers are.
- R10: In a running pipeline, a load followed directly by a dependent instruction stalls exactly one cycle. The bubble that results forwards nothing. The dependent instruction then receives select 2'b01 for the loaded register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs | input | AW | First source register of the instruction in decode |
| ifid_rt | input | AW | Second source register of the instruction in decode |
| idex_rs | input | AW | First source register of the instruction in execute |
| idex_rt | input | AW | Second source register (load target) of the instruction in execute |
| idex_mem_rd | input | 1 | Instruction in execute reads data memory |
| exmem_rd | input | AW | Destination register held after execute |
| exmem_wr | input | 1 | Instruction held after execute writes a register |
| memwb_rd | input | AW | Destination register held after memory access |
| memwb_wr | input | 1 | Instruction held after memory access writes a register |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |
| pc_hold | output | 1 | Freeze the program counter |
| ifid_hold | output | 1 | Freeze the decode pipeline register |
| idex_bubble | output | 1 | Clear control bits written into the execute register |

## Verification
Single-match patterns on each operand show whether the correct stage is chosen and whether the two operands are compared against the right fields. Patterns where both stages match tell the priority apart, and patterns with register 0 or with write enables low tell the qualifying conditions apart. Load-use patterns cover a match on either decode field, a mismatch, and a match with the memory-read flag low. A short instruction sequence run through a bench pipeline model checks that the stall lasts exactly one cycle, that the bubble does not forward, and that the loaded value then arrives through the post-memory path.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_MEMWB = 2'b01,
    FWD_EXMEM = 2'b10
  } fwd_sel_e;

  localparam int N_OPERANDS = 2;
endpackage

// File: rtl/hz_fwd_lane.sv
module hz_fwd_lane
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_reg,
  input  logic [AW-1:0] exmem_rd,
  input  logic          exmem_wr,
  input  logic [AW-1:0] memwb_rd,
  input  logic          memwb_wr,
  output fwd_sel_e      sel
);
  localparam logic [AW-1:0] REG_ZERO = '0;

  logic ex_hit;
  logic wb_hit;

  always_comb begin
    ex_hit = exmem_wr && (exmem_rd != REG_ZERO) && (exmem_rd == src_reg);
    wb_hit = memwb_wr && (memwb_rd != REG_ZERO) && (memwb_rd == src_reg);
    if (ex_hit)      sel = FWD_EXMEM;
    else if (wb_hit) sel = FWD_MEMWB;
    else             sel = FWD_RF;
  end

  always_comb begin
    a_r7_no_code_11: assert (sel != 2'b11);
    if (src_reg == REG_ZERO) begin
      a_r4_zero_not_forwarded: assert (sel == FWD_RF);
    end
    if (!exmem_wr && !memwb_wr) begin
      a_r5_no_write_no_fwd: assert (sel == FWD_RF);
    end
    if (exmem_wr && memwb_wr && exmem_rd == memwb_rd && exmem_rd == src_reg
        && src_reg != REG_ZERO) begin
      a_r3_newer_wins: assert (sel == FWD_EXMEM);
    end
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int AW = 5
) (
  input  logic          idex_mem_rd,
  input  logic [AW-1:0] idex_rt,
  input  logic [AW-1:0] ifid_rs,
  input  logic [AW-1:0] ifid_rt,
  output logic          hit
);
  logic rs_dep;
  logic rt_dep;

  always_comb begin
    rs_dep = (idex_rt == ifid_rs);
    rt_dep = (idex_rt == ifid_rt);
    hit    = idex_mem_rd && (rs_dep || rt_dep);
  end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] ifid_rs,
  input  logic [AW-1:0] ifid_rt,
  input  logic [AW-1:0] idex_rs,
  input  logic [AW-1:0] idex_rt,
  input  logic          idex_mem_rd,
  input  logic [AW-1:0] exmem_rd,
  input  logic          exmem_wr,
  input  logic [AW-1:0] memwb_rd,
  input  logic          memwb_wr,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble
);
  logic [AW-1:0] lane_src [N_OPERANDS];
  fwd_sel_e      lane_sel [N_OPERANDS];
  logic          lu_hit;

  assign lane_src[0] = idex_rs;
  assign lane_src[1] = idex_rt;

  for (genvar g = 0; g < N_OPERANDS; g++) begin : g_lane
    hz_fwd_lane #(.AW(AW)) u_lane (
      .src_reg  (lane_src[g]),
      .exmem_rd (exmem_rd),
      .exmem_wr (exmem_wr),
      .memwb_rd (memwb_rd),
      .memwb_wr (memwb_wr),
      .sel      (lane_sel[g])
    );
  end

  hz_load_use #(.AW(AW)) u_lu (
    .idex_mem_rd (idex_mem_rd),
    .idex_rt     (idex_rt),
    .ifid_rs     (ifid_rs),
    .ifid_rt     (ifid_rt),
    .hit         (lu_hit)
  );

  assign fwd_a       = lane_sel[0];
  assign fwd_b       = lane_sel[1];
  assign pc_hold     = lu_hit;
  assign ifid_hold   = lu_hit;
  assign idex_bubble = lu_hit;

  always_comb begin
    if (!idex_mem_rd) begin
      a_r9_no_stall_without_load: assert (!pc_hold && !idex_bubble);
    end
    if (idex_mem_rd && idex_rt == ifid_rs) begin
      a_r8_stall_on_rs_match: assert (pc_hold && ifid_hold && idex_bubble);
    end
  end
endmodule

// File: tb/hz_unit_test.sv
module hz_unit_test;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  // direct stimulus
  logic [AW-1:0] d_ifid_rs = '0, d_ifid_rt = '0, d_idex_rs = '0, d_idex_rt = '0;
  logic [AW-1:0] d_exmem_rd = '0, d_memwb_rd = '0;
  logic d_idex_mem_rd = 1'b0, d_exmem_wr = 1'b0, d_memwb_wr = 1'b0;

  // pipeline model: {rs, rt, dest, wr, ld}
  typedef struct packed {
    logic [AW-1:0] rs;
    logic [AW-1:0] rt;
    logic [AW-1:0] dst;
    logic          wr;
    logic          ld;
  } ins_t;

  ins_t prog [4];
  ins_t p_ifid = '0, p_idex = '0, p_exmem = '0, p_memwb = '0;
  int   pc = 0;
  logic pipe_mode = 1'b0;
  logic pipe_run  = 1'b0;

  logic [AW-1:0] ifid_rs, ifid_rt, idex_rs, idex_rt, exmem_rd, memwb_rd;
  logic idex_mem_rd, exmem_wr, memwb_wr;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, ifid_hold, idex_bubble;

  always_comb begin
    if (pipe_mode) begin
      ifid_rs = p_ifid.rs;   ifid_rt = p_ifid.rt;
      idex_rs = p_idex.rs;   idex_rt = p_idex.rt;   idex_mem_rd = p_idex.ld;
      exmem_rd = p_exmem.dst; exmem_wr = p_exmem.wr;
      memwb_rd = p_memwb.dst; memwb_wr = p_memwb.wr;
    end else begin
      ifid_rs = d_ifid_rs;   ifid_rt = d_ifid_rt;
      idex_rs = d_idex_rs;   idex_rt = d_idex_rt;   idex_mem_rd = d_idex_mem_rd;
      exmem_rd = d_exmem_rd; exmem_wr = d_exmem_wr;
      memwb_rd = d_memwb_rd; memwb_wr = d_memwb_wr;
    end
  end

  hz_unit #(.AW(AW)) uut (
    .ifid_rs(ifid_rs), .ifid_rt(ifid_rt), .idex_rs(idex_rs), .idex_rt(idex_rt),
    .idex_mem_rd(idex_mem_rd), .exmem_rd(exmem_rd), .exmem_wr(exmem_wr),
    .memwb_rd(memwb_rd), .memwb_wr(memwb_wr), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
  );

  always @(posedge clk) begin
    if (pipe_run) begin
      ins_t next_idex;
      next_idex = p_ifid;
      if (idex_bubble) begin
        next_idex.wr = 1'b0;
        next_idex.ld = 1'b0;
      end
      p_memwb <= p_exmem;
      p_exmem <= p_idex;
      p_idex  <= next_idex;
      if (!ifid_hold) p_ifid <= (pc < 4) ? prog[pc] : '0;
      if (!pc_hold) pc <= pc + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int irs, input int irt, input int ers, input int ert,
                       input bit ld, input int xrd, input bit xwr,
                       input int wrd, input bit wwr);
    @(negedge clk);
    d_ifid_rs = AW'(irs); d_ifid_rt = AW'(irt);
    d_idex_rs = AW'(ers); d_idex_rt = AW'(ert); d_idex_mem_rd = ld;
    d_exmem_rd = AW'(xrd); d_exmem_wr = xwr;
    d_memwb_rd = AW'(wrd); d_memwb_wr = wwr;
    #1;
  endtask

  task automatic t_idle;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 idle fwd_a", fwd_a, 0);
    chk("R7 idle fwd_b", fwd_b, 0);
    chk("R9 idle stall", {pc_hold, ifid_hold, idex_bubble}, 0);
  endtask

  task automatic t_single_match;
    drive(0, 0, 3, 4, 0, 3, 1, 9, 1);
    chk("R1 exmem to A", fwd_a, 2);
    chk("R6 B unmatched", fwd_b, 0);
    drive(0, 0, 3, 4, 0, 8, 1, 3, 1);
    chk("R2 memwb to A", fwd_a, 1);
    drive(0, 0, 3, 4, 0, 4, 1, 3, 1);
    chk("R6 exmem to B", fwd_b, 2);
    chk("R6 A independent", fwd_a, 1);
  endtask

  task automatic t_priority;
    drive(0, 0, 7, 7, 0, 7, 1, 7, 1);
    chk("R3 both match A", fwd_a, 2);
    chk("R3 both match B", fwd_b, 2);
    drive(0, 0, 7, 7, 0, 7, 0, 7, 1);
    chk("R3 exmem no write falls back", fwd_a, 1);
  endtask

  task automatic t_zero_and_wr;
    drive(0, 0, 0, 0, 0, 0, 1, 0, 1);
    chk("R4 reg0 A", fwd_a, 0);
    chk("R4 reg0 B", fwd_b, 0);
    drive(0, 0, 5, 5, 0, 5, 0, 5, 0);
    chk("R5 no write A", fwd_a, 0);
    chk("R5 no write B", fwd_b, 0);
  endtask

  task automatic t_load_use;
    drive(6, 2, 1, 6, 1, 0, 0, 0, 0);
    chk("R8 rs match", {pc_hold, ifid_hold, idex_bubble}, 7);
    drive(2, 6, 1, 6, 1, 0, 0, 0, 0);
    chk("R8 rt match", {pc_hold, ifid_hold, idex_bubble}, 7);
    drive(2, 3, 1, 6, 1, 0, 0, 0, 0);
    chk("R8 no match", {pc_hold, ifid_hold, idex_bubble}, 0);
    drive(6, 6, 1, 6, 0, 0, 0, 0, 0);
    chk("R9 no load", {pc_hold, ifid_hold, idex_bubble}, 0);
  endtask

  task automatic t_pipeline;
    int stalls = 0;
    prog[0] = '{rs: 5'd1, rt: 5'd5, dst: 5'd5, wr: 1'b1, ld: 1'b1}; // load r5
    prog[1] = '{rs: 5'd5, rt: 5'd7, dst: 5'd6, wr: 1'b1, ld: 1'b0}; // uses r5
    prog[2] = '{rs: 5'd9, rt: 5'd6, dst: 5'd8, wr: 1'b1, ld: 1'b0}; // uses r6
    prog[3] = '0;
    @(negedge clk);
    pipe_mode = 1'b1;
    pipe_run  = 1'b1;
    @(negedge clk); // load in decode
    if (pc_hold) stalls++;
    @(negedge clk); // load in execute, user in decode
    if (pc_hold) stalls++;
    chk("R10 stall raised", {pc_hold, ifid_hold, idex_bubble}, 7);
    @(negedge clk); // bubble in execute
    if (pc_hold) stalls++;
    chk("R10 stall dropped", pc_hold, 0);
    @(negedge clk); // user in execute, load after memory
    if (pc_hold) stalls++;
    chk("R10 load value via memwb", fwd_a, 1);
    chk("R10 bubble not forwarded B", fwd_b, 0);
    @(negedge clk); // third in execute
    if (pc_hold) stalls++;
    chk("R10 bubble skipped, exmem to B", fwd_b, 2);
    chk("R10 A from rf", fwd_a, 0);
    chk("R10 one stall cycle", stalls, 1);
    pipe_run  = 1'b0;
    pipe_mode = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_idle();
    t_single_match();
    t_priority();
    t_zero_and_wr();
    t_load_use();
    t_pipeline();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule